// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a small parallel flash device, written as synchronous logic clocked by the chip clock. It samples the active-low write, chip-enable, output-enable and reset/power-down pins. A write takes effect on the rising edge of the write strobe while chip enable is low. The block decodes single-write commands that select what a read returns: array data, identifier bytes or the status byte. It also sequences the two-write erase and program commands.

When a two-write sequence completes with the programming voltage present, the block issues a one-cycle request to an external array engine. It clears the ready flag until the engine reports completion. Pulling the reset/power-down pin low turns the read outputs off and returns the block to its power-up state. If an operation is in progress, the block signals an abort. After the pin is released, two counted intervals gate writes and read outputs.

Top module: `flash_cmd_iface`

## Requirements
- R1: After `rst_n` is released, reads return array data (`arrayData`), the status byte is 80h, and no request or abort is signalled.
- R2: A write is taken only at the first clock where `weN` is sampled high after being sampled low while `ceN` is low. Toggling `weN` with `ceN` high changes nothing.
- R3: Writing FFh selects array reads. Writing 90h selects identifier reads: address 0 returns 89h, address 1 returns 94h (95h when `BOTTOM_BOOT`=1), and every other address returns 00h.
- R4: Writing 70h selects status reads. Status bit 7 is ready, bit 5 erase error, bit 4 program error and bit 3 low programming voltage; all other bits read 0. Command codes not listed in R3 to R10 are ignored.
- R5: Writing 20h followed by D0h, with both addresses in the same block (top `BLOCK_W` address bits) and `vppHigh` set at the second write, pulses `opStart` for one cycle. `opErase`=1 and `opAddr` equals the second address, and the ready bit clears.
- R6: If the write after 20h is not D0h, or addresses another block, status bit 5 is set, no request is issued, and reads return status.
- R7: Writing 40h followed by any write pulses `opStart` with `opErase`=0. `opAddr` and `opData` equal the address and data of that second write.
- R8: If `vppHigh` is low at the second write of an erase or program, bit 3 and the matching error bit (5 or 4) are set, and no request is issued.
- R9: From the start of an operation until `engDone`, ready is 0 and writes are ignored. `engDone` sets ready, and reads keep returning status until a new command.
- R10: Writing 50h clears status bits 5, 4 and 3 and leaves the read selection unchanged.
- R11: While `rpN` is low, `dataOe` is 0, the read selection returns to array, and status returns to 80h. If an operation was running, `opAbort` pulses once with `opAddr` still naming the affected location.
- R12: After `rpN` rises, a write whose strobe edge lands within the first `RECOVER_CYC` clocks is ignored. `dataOe` stays 0 for the first `WAKE_CYC` clocks.
- R13: `dataOe` is 1 only while `ceN` and `oeN` are both low, `rpN` is high and the wake interval has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous-logic reset, active low |
| weN | input | 1 | Write strobe, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| rpN | input | 1 | Reset / deep power-down pin, active low |
| addr | input | ADDR_W | Address bus |
| dataIn | input | 8 | Write data bus |
| vppHigh | input | 1 | Programming voltage present |
| arrayData | input | 8 | Byte read from the array at `addr` |
| engDone | input | 1 | Array engine finished the current operation |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Read data drive enable |
| opStart | output | 1 | One-cycle request to the array engine |
| opErase | output | 1 | Request kind: 1 erase, 0 program |
| opAddr | output | ADDR_W | Request address |
| opData | output | 8 | Program data |
| opAbort | output | 1 | One-cycle abort of the running operation |

## Verification
The assertions assume the pins are already synchronous to `clk`. They also assume that `engDone` arrives only after a request and that a strobe low phase spans at least one clock with stable address and data. The bench changes every pin only at falling clock edges and holds each strobe phase for a full clock. It raises `engDone` only after an observed `opStart`, and it changes `vppHigh` only between command sequences.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rdMode_t;

  typedef enum logic [1:0] {
    CS_IDLE      = 2'd0,
    CS_ERASE_ARM = 2'd1,
    CS_PROG_ARM  = 2'd2,
    CS_BUSY      = 2'd3
  } cmdState_t;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic loadSetup;   // remember block of a setup write
    logic loadOp;      // capture request address/data
    logic markBusy;    // clear ready
    logic markReady;   // set ready
    logic flagErase;   // set erase error bit
    logic flagProg;    // set program error bit
    logic flagVolt;    // set low-voltage bit
    logic clearErr;    // clear error bits
    logic restore;     // power-down restore of status
  } dpStrobe_t;

  localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_IDENT         = 8'h90;
  localparam logic [7:0] CMD_STATUS        = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP   = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP    = 8'h40;

  localparam logic [7:0] STATUS_RESET  = 8'h80;
  localparam int         BIT_READY     = 7;
  localparam int         BIT_ERASE_ERR = 5;
  localparam int         BIT_PROG_ERR  = 4;
  localparam int         BIT_VOLT_ERR  = 3;

  localparam logic [7:0] ID_MAKER      = 8'h89;
  localparam logic [7:0] ID_DEV_TOP    = 8'h94;
  localparam logic [7:0] ID_DEV_BOTTOM = 8'h95;

endpackage

// File: rtl/flash_hold_timer.sv
module flash_hold_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic expired
);

  generate
    if (CYC == 0) begin : g_none
      assign expired = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(CYC + 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (hold) begin
          cnt <= CW'(CYC);
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign expired = (cnt == '0);
    end
  endgenerate

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int RECOVER_CYC = 4,
  parameter int WAKE_CYC    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       weN,
  input  logic       ceN,
  input  logic       rpN,
  input  logic       vppHigh,
  input  logic       engDone,
  input  logic [7:0] wrData,
  input  logic       blockMatch,
  output dpStrobe_t  strobe,
  output rdMode_t    rdMode,
  output logic       busy,
  output logic       wakeDone,
  output logic       opStart,
  output logic       opErase,
  output logic       opAbort
);

  cmdState_t state, stateNext;
  rdMode_t   modeNext;
  logic      weNq;
  logic      writeReady;
  logic      weRise;
  logic      startNext, eraseNext, abortNext;

  flash_hold_timer #(.CYC(RECOVER_CYC)) uRecover (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (~rpN),
    .expired(writeReady)
  );

  flash_hold_timer #(.CYC(WAKE_CYC)) uWake (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (~rpN),
    .expired(wakeDone)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) weNq <= 1'b1;
    else        weNq <= weN;
  end

  assign weRise = weN & ~weNq & ~ceN & rpN & writeReady;
  assign busy   = (state == CS_BUSY);

  always_comb begin
    stateNext = state;
    modeNext  = rdMode;
    strobe    = '0;
    startNext = 1'b0;
    eraseNext = opErase;
    abortNext = 1'b0;
    if (!rpN) begin
      stateNext      = CS_IDLE;
      modeNext       = RD_ARRAY;
      strobe.restore = 1'b1;
      abortNext      = (state == CS_BUSY);
    end else begin
      if (state == CS_BUSY && engDone) begin
        stateNext        = CS_IDLE;
        strobe.markReady = 1'b1;
      end
      if (weRise) begin
        case (state)
          CS_IDLE: begin
            case (wrData)
              CMD_READ_ARRAY:   modeNext = RD_ARRAY;
              CMD_IDENT:        modeNext = RD_IDENT;
              CMD_STATUS:       modeNext = RD_STATUS;
              CMD_CLEAR_STATUS: strobe.clearErr = 1'b1;
              CMD_ERASE_SETUP: begin
                stateNext        = CS_ERASE_ARM;
                modeNext         = RD_STATUS;
                strobe.loadSetup = 1'b1;
              end
              CMD_PROG_SETUP: begin
                stateNext        = CS_PROG_ARM;
                modeNext         = RD_STATUS;
                strobe.loadSetup = 1'b1;
              end
              default: ;
            endcase
          end
          CS_ERASE_ARM: begin
            stateNext = CS_IDLE;
            modeNext  = RD_STATUS;
            if (wrData != CMD_ERASE_CONFIRM || !blockMatch) begin
              strobe.flagErase = 1'b1;
            end else if (!vppHigh) begin
              strobe.flagErase = 1'b1;
              strobe.flagVolt  = 1'b1;
            end else begin
              stateNext       = CS_BUSY;
              strobe.loadOp   = 1'b1;
              strobe.markBusy = 1'b1;
              startNext       = 1'b1;
              eraseNext       = 1'b1;
            end
          end
          CS_PROG_ARM: begin
            stateNext = CS_IDLE;
            modeNext  = RD_STATUS;
            if (!vppHigh) begin
              strobe.flagProg = 1'b1;
              strobe.flagVolt = 1'b1;
            end else begin
              stateNext       = CS_BUSY;
              strobe.loadOp   = 1'b1;
              strobe.markBusy = 1'b1;
              startNext       = 1'b1;
              eraseNext       = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= CS_IDLE;
      rdMode  <= RD_ARRAY;
      opStart <= 1'b0;
      opErase <= 1'b0;
      opAbort <= 1'b0;
    end else begin
      state   <= stateNext;
      rdMode  <= modeNext;
      opStart <= startNext;
      opErase <= eraseNext;
      opAbort <= abortNext;
    end
  end

  AST_START_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({opStart, opAbort})); // R11
  AST_ABORT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    opAbort |-> !busy && rdMode == RD_ARRAY); // R11
  AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    opStart |-> busy && rdMode == RD_STATUS); // R9

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int BLOCK_W     = 3,
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  rdMode_t           rdMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        arrayData,
  input  logic              rpN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              wakeDone,
  input  logic              busy,
  input  logic              opStart,
  input  logic              engDone,
  input  logic              vppHigh,
  output logic              blockMatch,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  localparam logic [7:0] DEV_CODE = BOTTOM_BOOT ? ID_DEV_BOTTOM : ID_DEV_TOP;

  logic [BLOCK_W-1:0] setupBlock;
  logic [7:0]         statusReg, statusNext;
  logic [7:0]         identByte;

  assign blockMatch = (addr[ADDR_W-1 -: BLOCK_W] == setupBlock);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setupBlock <= '0;
      opAddr     <= '0;
      opData     <= '0;
    end else begin
      if (strobe.loadSetup) setupBlock <= addr[ADDR_W-1 -: BLOCK_W];
      if (strobe.loadOp) begin
        opAddr <= addr;
        opData <= wrData;
      end
    end
  end

  always_comb begin
    statusNext = statusReg;
    if (strobe.restore) begin
      statusNext = STATUS_RESET;
    end else begin
      if (strobe.markBusy)  statusNext[BIT_READY] = 1'b0;
      if (strobe.markReady) statusNext[BIT_READY] = 1'b1;
      if (strobe.clearErr) begin
        statusNext[BIT_ERASE_ERR] = 1'b0;
        statusNext[BIT_PROG_ERR]  = 1'b0;
        statusNext[BIT_VOLT_ERR]  = 1'b0;
      end
      if (strobe.flagErase) statusNext[BIT_ERASE_ERR] = 1'b1;
      if (strobe.flagProg)  statusNext[BIT_PROG_ERR]  = 1'b1;
      if (strobe.flagVolt)  statusNext[BIT_VOLT_ERR]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) statusReg <= STATUS_RESET;
    else        statusReg <= statusNext;
  end

  always_comb begin
    if (addr == ADDR_W'(0))      identByte = ID_MAKER;
    else if (addr == ADDR_W'(1)) identByte = DEV_CODE;
    else                         identByte = 8'h00;
  end

  always_comb begin
    case (rdMode)
      RD_IDENT:  dataOut = identByte;
      RD_STATUS: dataOut = statusReg;
      default:   dataOut = arrayData;
    endcase
  end

  assign dataOe = rpN & wakeDone & ~ceN & ~oeN;

  AST_START_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    opStart |-> !statusReg[BIT_READY]); // R5
  AST_START_NEEDS_VOLT: assert property (@(posedge clk) disable iff (!rst_n)
    opStart |-> $past(vppHigh)); // R8
  AST_POWERDOWN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    !rpN |=> statusReg == STATUS_RESET && rdMode == RD_ARRAY); // R11
  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && engDone && rpN |=> statusReg[BIT_READY]); // R9
  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    statusReg[6] == 1'b0 && statusReg[2:0] == 3'b000); // R4

endmodule

// File: rtl/flash_cmd_iface.sv
module flash_cmd_iface
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int BLOCK_W     = 3,
  parameter bit BOTTOM_BOOT = 1'b0,
  parameter int RECOVER_CYC = 4,
  parameter int WAKE_CYC    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              weN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              rpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              vppHigh,
  input  logic [7:0]        arrayData,
  input  logic              engDone,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              opStart,
  output logic              opErase,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic              opAbort
);

  dpStrobe_t strobe;
  rdMode_t   rdMode;
  logic      busy;
  logic      wakeDone;
  logic      blockMatch;

  flash_cmd_fsm #(
    .RECOVER_CYC(RECOVER_CYC),
    .WAKE_CYC   (WAKE_CYC)
  ) uFsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .weN       (weN),
    .ceN       (ceN),
    .rpN       (rpN),
    .vppHigh   (vppHigh),
    .engDone   (engDone),
    .wrData    (dataIn),
    .blockMatch(blockMatch),
    .strobe    (strobe),
    .rdMode    (rdMode),
    .busy      (busy),
    .wakeDone  (wakeDone),
    .opStart   (opStart),
    .opErase   (opErase),
    .opAbort   (opAbort)
  );

  flash_cmd_dp #(
    .ADDR_W     (ADDR_W),
    .BLOCK_W    (BLOCK_W),
    .BOTTOM_BOOT(BOTTOM_BOOT)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .rdMode    (rdMode),
    .addr      (addr),
    .wrData    (dataIn),
    .arrayData (arrayData),
    .rpN       (rpN),
    .ceN       (ceN),
    .oeN       (oeN),
    .wakeDone  (wakeDone),
    .busy      (busy),
    .opStart   (opStart),
    .engDone   (engDone),
    .vppHigh   (vppHigh),
    .blockMatch(blockMatch),
    .opAddr    (opAddr),
    .opData    (opData),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

endmodule

// File: tb/sim_flash_cmd_iface.sv
module sim_flash_cmd_iface;

  localparam int ADDR_W  = 8;
  localparam int BLOCK_W = 2;
  localparam int REC     = 4;
  localparam int WAKE    = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              weN = 1'b1, ceN = 1'b1, oeN = 1'b1, rpN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dataIn = '0;
  logic              vppHigh = 1'b0, engDone = 1'b0;
  logic [7:0]        arrayData;
  logic [7:0]        dataOut;
  logic              dataOe, opStart, opErase, opAbort;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // array model: each byte is its address xor A5h
  assign arrayData = addr ^ 8'hA5;

  flash_cmd_iface #(
    .ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .BOTTOM_BOOT(1'b0),
    .RECOVER_CYC(REC), .WAKE_CYC(WAKE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .weN(weN), .ceN(ceN), .oeN(oeN), .rpN(rpN),
    .addr(addr), .dataIn(dataIn), .vppHigh(vppHigh), .arrayData(arrayData),
    .engDone(engDone), .dataOut(dataOut), .dataOe(dataOe), .opStart(opStart),
    .opErase(opErase), .opAddr(opAddr), .opData(opData), .opAbort(opAbort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask

  task automatic wrNoCe(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b1; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0;
    #1 chk(req, {dataOe, dataOut}, {1'b1, exp});
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic engPulse();
    @(negedge clk); engDone = 1'b1;
    @(negedge clk); engDone = 1'b0;
  endtask

  // rpN low for two clocks; returns at the falling edge where rpN rises
  task automatic rpLow();
    @(negedge clk); rpN = 1'b0;
    @(negedge clk);
    @(negedge clk); rpN = 1'b1;
  endtask

  task automatic rpCycle();
    rpLow();
    repeat (WAKE + 1) @(negedge clk);
  endtask

  function automatic logic [7:0] expAfterCode(input logic [7:0] c);
    case (c)
      8'h90:               return 8'h89;
      8'h70, 8'h20, 8'h40: return 8'h80;
      default:             return 8'h00 ^ 8'hA5;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 no request", {opStart, opAbort}, 2'b00);
    chk("R13 oe off with ce high", dataOe, 1'b0);
    rd("R1 array read", 8'h3C, 8'h3C ^ 8'hA5);
    wr(8'h00, 8'h70);
    rd("R1 status reset", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    rd("R3 back to array", 8'h11, 8'h11 ^ 8'hA5);

    // R13 output enable needs both enables
    @(negedge clk); ceN = 1'b0; oeN = 1'b1;
    #1 chk("R13 oe off with oeN high", dataOe, 1'b0);
    ceN = 1'b1;

    // R2 write without chip enable is ignored
    wrNoCe(8'h00, 8'h90);
    rd("R2 ignored without ce", 8'h00, 8'hA5);

    // R3 identifier sweep over every address
    wr(8'h00, 8'h90);
    for (int a = 0; a < 256; a++) begin
      rd("R3 ident", 8'(a), (a == 0) ? 8'h89 : (a == 1) ? 8'h94 : 8'h00);
    end

    // R4 R11 sweep of every command code from a fresh power-down exit
    for (int c = 0; c < 256; c++) begin
      rpCycle();
      wr(8'h00, 8'(c));
      rd("R4 code sweep", 8'h00, expAfterCode(8'(c)));
    end

    // R5 erase with matching block and voltage
    rpCycle();
    vppHigh = 1'b1;
    wr(8'h45, 8'h20);
    wr(8'h7F, 8'hD0);
    chk("R5 erase start", {opStart, opErase, opAddr}, {1'b1, 1'b1, 8'h7F});
    @(negedge clk);
    chk("R5 single pulse", opStart, 1'b0);
    rd("R5 ready cleared", 8'h00, 8'h00);
    // R9 writes ignored while busy
    wr(8'h00, 8'hFF);
    rd("R9 busy ignores write", 8'h00, 8'h00);
    engPulse();
    rd("R9 done sets ready", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    rd("R9 new command after done", 8'h02, 8'h02 ^ 8'hA5);

    // R6 wrong confirm code
    wr(8'h45, 8'h20);
    wr(8'h46, 8'hD1);
    chk("R6 no start", opStart, 1'b0);
    rd("R6 erase error", 8'h00, 8'hA0);
    // R10 clear keeps status selection
    wr(8'h00, 8'h50);
    rd("R10 cleared, still status", 8'h00, 8'h80);
    // R6 other block
    wr(8'h45, 8'h20);
    wr(8'hC5, 8'hD0);
    chk("R6 no start block", opStart, 1'b0);
    rd("R6 block mismatch", 8'h00, 8'hA0);
    wr(8'h00, 8'h50);

    // R8 low voltage on erase and program
    vppHigh = 1'b0;
    wr(8'h45, 8'h20);
    wr(8'h45, 8'hD0);
    chk("R8 no erase start", opStart, 1'b0);
    rd("R8 erase volt", 8'h00, 8'hA8);
    wr(8'h00, 8'h50);
    wr(8'h10, 8'h40);
    wr(8'h33, 8'h5C);
    chk("R8 no program start", opStart, 1'b0);
    rd("R8 program volt", 8'h00, 8'h98);
    wr(8'h00, 8'h50);
    rd("R10 clear all", 8'h00, 8'h80);

    // R7 program
    vppHigh = 1'b1;
    wr(8'h10, 8'h40);
    wr(8'h33, 8'h5C);
    chk("R7 program start", {opStart, opErase, opAddr, opData}, {1'b1, 1'b0, 8'h33, 8'h5C});
    rd("R7 busy status", 8'h00, 8'h00);
    engPulse();
    rd("R7 done", 8'h00, 8'h80);

    // R11 abort during erase
    wr(8'h81, 8'h20);
    wr(8'h82, 8'hD0);
    @(negedge clk); rpN = 1'b0; ceN = 1'b0; oeN = 1'b0;
    #1 chk("R11 outputs off", dataOe, 1'b0);
    @(negedge clk);
    chk("R11 abort pulse", {opAbort, opAddr}, {1'b1, 8'h82});
    @(negedge clk);
    chk("R11 abort single", opAbort, 1'b0);
    rpN = 1'b1; ceN = 1'b1; oeN = 1'b1;
    repeat (WAKE + 1) @(negedge clk);
    rd("R11 array after abort", 8'h05, 8'h05 ^ 8'hA5);
    wr(8'h00, 8'h70);
    rd("R11 status restored", 8'h00, 8'h80);

    // R12 wake interval boundary
    rpLow();
    ceN = 1'b0; oeN = 1'b0;
    repeat (WAKE - 1) @(negedge clk);
    #1 chk("R12 still asleep", dataOe, 1'b0);
    @(negedge clk);
    #1 chk("R12 awake", dataOe, 1'b1);
    ceN = 1'b1; oeN = 1'b1;

    // R12 recovery boundary: strobe edge at clock REC is ignored
    rpLow();
    @(negedge clk);
    wr(8'h00, 8'h90);
    repeat (WAKE) @(negedge clk);
    rd("R12 early write ignored", 8'h00, 8'hA5);
    // strobe edge at clock REC+1 is taken
    rpLow();
    repeat (2) @(negedge clk);
    wr(8'h00, 8'h90);
    repeat (WAKE) @(negedge clk);
    rd("R12 write after recovery", 8'h00, 8'h89);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule